// File: doc/BRIEF.md
# Six-Rail Power Sequencing Controller

This block drives six power-rail enable outputs. When a power-up request is held high, every precondition bit is high and the slot configuration is valid, it switches the rails on one at a time. Each channel's slot number sets where that channel falls in the power-up order. When the request is dropped, the rails switch off one at a time. A configuration bit chooses the switch-off order: either the power-up order or its reverse. The same programmable delay spaces the power-up steps and the power-down steps.

An active-low force-off input overrides the sequencing. It clears all enables together and holds the block in a latched forced state. To leave that state, force-off must be released and the request must be seen low. A new power-up then needs a fresh high request. The request and force-off inputs are asynchronous, and each passes through a two-flop synchronizer. Slot numbers, delay, off-order and preconditions are plain parallel inputs, and they are expected to change only while the rails are off.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, all enables are low, `state_o` is 0 (off) and `busy_o` is low.
- R2: Power-up starts only when the synchronized request is high, every bit of `precond_i` is high and `cfg_err_o` is low. Two synchronizer flops plus the state register separate a request edge from the change of state. With any precondition bit low, the block stays off.
- R3: Each step lasts `step_dly_i`+1 clock cycles, counted from entry into the power-up state. At the end of each step, one more enable rises: the channel whose 3-bit slot field (`slot_i[3*ch+2:3*ch]`) equals the number of steps already taken. After the sixth step the state is on and all six enables are high.
- R4: `cfg_err_o` is high whenever the six slot fields are not a permutation of 0..5 (a value is repeated, or a value is above 5). While it is high, power-up never starts.
- R5: Dropping the request in the on state starts power-down. One enable falls per step, with the step length from R3. With `off_rev_i`=1 the highest enabled slot falls first. With `off_rev_i`=0 the lowest enabled slot falls first. When the last enable falls, the state returns to off.
- R6: If the request drops during power-up, only the channels already enabled are switched off, in the order selected by R5, and then the state returns to off.
- R7: On the third rising edge after `force_off_ni` falls, every enable goes low together and the state becomes forced-off. This holds in every state.
- R8: The forced-off state holds while the synchronized request is high, even after force-off is released. It exits to off only once force-off is high and the request is seen low. A later high request then restarts power-up.
- R9: `state_o` encodes off=0, powering-up=1, on=2, powering-down=3 and forced-off=4. `busy_o` is high exactly in states 1 and 3.
- R10: A request that rises again during power-down is ignored until the state reaches off. If the request is still high at that point, power-up begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Power-up request, asynchronous |
| force_off_ni | input | 1 | Force all rails off, active low, asynchronous |
| precond_i | input | 6 | Preconditions; all must be high to start |
| slot_i | input | 18 | Per-channel 3-bit slot number, channel 0 in bits 2:0 |
| step_dly_i | input | 16 | Extra cycles per step (step = value + 1 cycles) |
| off_rev_i | input | 1 | 1: power-down in reverse slot order, 0: same order |
| en_o | output | 6 | Rail enables |
| state_o | output | 3 | Sequencer state code |
| busy_o | output | 1 | High while powering up or down |
| cfg_err_o | output | 1 | Slot fields are not a permutation |

## Verification
Two events can land on the same edge: the request dropping while a power-up step is ending, and a force-off arriving in the middle of a sequence. The bench provokes these in two ways. It drops the request partway through a slow power-up, and it raises the request again during power-down. It also asserts force-off from the on state and then releases it while the request is still high. A behavioural model keeps the enabled channels in a queue, pushing on power-up and popping at either end on power-down. The model is compared against the enables, state, busy and error outputs on every cycle, so it catches both a step that is lost to a reversal and a step that fires twice.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_SEQ_ON  = 3'd1,
    ST_ON      = 3'd2,
    ST_SEQ_OFF = 3'd3,
    ST_FORCED  = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pwr_seq_slot_map.sv
module pwr_seq_slot_map #(
  parameter int N_CH   = 6,
  parameter int SLOT_W = 3,
  parameter int PTR_W  = 3
) (
  input  logic [N_CH*SLOT_W-1:0] slot_i,
  input  logic [PTR_W-1:0]       lo_i,
  input  logic [PTR_W-1:0]       hi_i,
  output logic                   cfg_err_o,
  output logic [N_CH-1:0]        en_o
);
  logic [N_CH-1:0] match [N_CH];

  // match[s][ch]: channel ch claims slot s
  for (genvar s = 0; s < N_CH; s++) begin : g_slot
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      assign match[s][ch] = (slot_i[ch*SLOT_W +: SLOT_W] == SLOT_W'(s));
    end
  end

  always_comb begin
    cfg_err_o = 1'b0;
    for (int s = 0; s < N_CH; s++) begin
      if ($countones(match[s]) != 1) cfg_err_o = 1'b1;
    end
  end

  // live window of slots is [lo, hi)
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_en
    assign en_o[ch] = (int'(slot_i[ch*SLOT_W +: SLOT_W]) >= int'(lo_i)) &&
                      (int'(slot_i[ch*SLOT_W +: SLOT_W]) <  int'(hi_i));
  end
endmodule

// File: rtl/pwr_seq_step_timer.sv
module pwr_seq_step_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q;

  assign expire_o = (cnt_q == dly_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R3: a finished step restarts the count
  a_r3_step_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == '0);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int  N_CH   = 6,
  parameter int  DLY_W  = 16,
  localparam int SLOT_W = $clog2(N_CH),
  localparam int PTR_W  = $clog2(N_CH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pwr_req_i,
  input  logic                   force_off_ni,
  input  logic [N_CH-1:0]        precond_i,
  input  logic [N_CH*SLOT_W-1:0] slot_i,
  input  logic [DLY_W-1:0]       step_dly_i,
  input  logic                   off_rev_i,
  output logic [N_CH-1:0]        en_o,
  output logic [2:0]             state_o,
  output logic                   busy_o,
  output logic                   cfg_err_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_CH - 1);

  pwr_state_e       state_q, state_n;
  logic [PTR_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic [1:0]       sync_in, sync_out;
  logic             req_s, fo_n_s, step, tmr_clr;

  assign sync_in = {force_off_ni, pwr_req_i};

  pwr_seq_sync #(.W(2), .RST_VAL(2'b10)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );
  assign req_s  = sync_out[0];
  assign fo_n_s = sync_out[1];

  pwr_seq_slot_map #(.N_CH(N_CH), .SLOT_W(SLOT_W), .PTR_W(PTR_W)) i_map (
    .slot_i   (slot_i),
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .cfg_err_o(cfg_err_o),
    .en_o     (en_o)
  );

  pwr_seq_step_timer #(.DLY_W(DLY_W)) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .dly_i   (step_dly_i),
    .expire_o(step)
  );

  always_comb begin
    state_n = state_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    if (!fo_n_s) begin
      state_n = ST_FORCED;
      lo_n    = '0;
      hi_n    = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          lo_n = '0;
          hi_n = '0;
          if (req_s && (&precond_i) && !cfg_err_o) state_n = ST_SEQ_ON;
        end
        ST_SEQ_ON: begin
          if (!req_s) state_n = ST_SEQ_OFF;
          else if (step) begin
            hi_n = hi_q + 1'b1;
            if (hi_q == LAST) state_n = ST_ON;
          end
        end
        ST_ON: if (!req_s) state_n = ST_SEQ_OFF;
        ST_SEQ_OFF: begin
          if (lo_q == hi_q) state_n = ST_OFF;
          else if (step) begin
            if (off_rev_i) hi_n = hi_q - 1'b1;
            else           lo_n = lo_q + 1'b1;
            if (hi_q - lo_q == PTR_W'(1)) state_n = ST_OFF;
          end
        end
        ST_FORCED: if (!req_s) state_n = ST_OFF;
        default: state_n = ST_OFF;
      endcase
    end
  end

  assign busy_o  = (state_q == ST_SEQ_ON) || (state_q == ST_SEQ_OFF);
  assign tmr_clr = (state_n != state_q) || !busy_o;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_n;
      lo_q    <= lo_n;
      hi_q    <= hi_n;
    end
  end

  a_r7_force_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fo_n_s |=> (en_o == '0) && (state_q == ST_FORCED));

  a_r5_off_no_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF |-> en_o == '0);

  a_r3_on_all_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ON |-> &en_o);

  a_r3_one_per_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fo_n_s && state_q != ST_FORCED |=> $countones(en_o ^ $past(en_o)) <= 1);

  a_r4_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && state_q == ST_OFF |=> state_q != ST_SEQ_ON);

  a_r8_forced_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FORCED && req_s |=> state_q == ST_FORCED);

  a_r10_off_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SEQ_OFF && fo_n_s |=> state_q == ST_SEQ_OFF || state_q == ST_OFF);
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_ni, pwr_req, force_n, off_rev;
  logic [5:0]  precond;
  logic [17:0] slots;
  logic [15:0] dly;
  logic [5:0]  en;
  logic [2:0]  state;
  logic        busy, cfg_err;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_req_i(pwr_req), .force_off_ni(force_n),
    .precond_i(precond), .slot_i(slots), .step_dly_i(dly), .off_rev_i(off_rev),
    .en_o(en), .state_o(state), .busy_o(busy), .cfg_err_o(cfg_err)
  );

  // ---------------- reference model ----------------
  int m_state, m_tmr, ns;
  int on_q[$];
  int ord[N];
  bit r1, r2, f1, f2, stp;

  function automatic bit perm_bad(input logic [17:0] s);
    int cnt[8];
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    for (int c = 0; c < N; c++) cnt[s[c*3 +: 3]]++;
    for (int i = 0; i < N; i++) if (cnt[i] != 1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [5:0] model_en();
    logic [5:0] e = '0;
    foreach (on_q[i]) e[on_q[i]] = 1'b1;
    return e;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_tmr = 0; on_q.delete();
      r1 = 0; r2 = 0; f1 = 1; f2 = 1;
    end else begin
      for (int c = 0; c < N; c++) ord[slots[c*3 +: 3] % N] = c;
      ns  = m_state;
      stp = (m_tmr == int'(dly));
      if (!f2) begin
        ns = 4; on_q.delete();
      end else begin
        case (m_state)
          0: if (r2 && (&precond) && !perm_bad(slots)) ns = 1;
          1: if (!r2) ns = 3;
             else if (stp) begin
               on_q.push_back(ord[on_q.size()]);
               if (on_q.size() == N) ns = 2;
             end
          2: if (!r2) ns = 3;
          3: if (on_q.size() == 0) ns = 0;
             else if (stp) begin
               if (off_rev) void'(on_q.pop_back());
               else         void'(on_q.pop_front());
               if (on_q.size() == 0) ns = 0;
             end
          default: if (!r2) ns = 0;
        endcase
      end
      if (ns != m_state || !(m_state == 1 || m_state == 3)) m_tmr = 0;
      else if (stp) m_tmr = 0;
      else m_tmr++;
      r2 = r1; r1 = pwr_req; f2 = f1; f1 = force_n;
      m_state = ns;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    chk("R3 enables", 32'(en), 32'(model_en()));
    chk("R9 state", 32'(state), 32'(m_state));
    chk("R9 busy", 32'(busy), 32'(m_state == 1 || m_state == 3));
    chk("R4 cfg_err", 32'(cfg_err), 32'(perm_bad(slots)));
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drv_req(input logic v);
    @(negedge clk); #2 pwr_req = v;
  endtask

  task automatic wait_state(input string tag, input int s, input int max);
    for (int i = 0; i < max; i++) begin
      if (state == 3'(s)) break;
      @(negedge clk);
    end
    chk(tag, 32'(state), 32'(s));
  endtask

  function automatic logic [17:0] pack(input int a0, a1, a2, a3, a4, a5);
    return {3'(a5), 3'(a4), 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
  endfunction

  initial begin
    rst_ni = 0; pwr_req = 0; force_n = 1; off_rev = 1;
    precond = '1; dly = 16'd2; slots = pack(2, 0, 5, 1, 4, 3);
    repeat (3) @(negedge clk);
    chk("R1 en", 32'(en), 0); chk("R1 state", 32'(state), 0); chk("R1 busy", 32'(busy), 0);
    #2 rst_ni = 1;
    @(negedge clk);
    chk("R1 state after release", 32'(state), 0);

    // R3 / R5 reverse off
    drv_req(1);
    wait_state("R3 reach on", 2, 200);
    chk("R3 all on", 32'(en), 32'h3f);
    drv_req(0);
    wait_state("R5 seq off", 3, 10);
    wait_state("R5 reach off", 0, 200);

    // R2 missing precondition, then R5 same-order off
    off_rev = 0; precond = 6'b110111;
    drv_req(1);
    repeat (20) @(negedge clk);
    chk("R2 precond blocks", 32'(state), 0);
    #2 precond = '1;
    wait_state("R2 start", 1, 10);
    wait_state("R2 on", 2, 200);
    drv_req(0);
    wait_state("R5 same order off", 0, 200);

    // R6 abort mid power-up
    dly = 16'd4; off_rev = 1;
    drv_req(1);
    repeat (15) @(negedge clk);
    chk("R6 mid power-up", 32'(state), 1);
    chk("R6 partial", 32'($countones(en) inside {[1:5]}), 1);
    drv_req(0);
    wait_state("R6 back off", 0, 100);

    // R7 / R8 forced off
    dly = 16'd1;
    drv_req(1);
    wait_state("R7 on", 2, 100);
    @(negedge clk); #2 force_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 en cleared", 32'(en), 0);
    chk("R7 forced", 32'(state), 4);
    #2 force_n = 1;
    repeat (10) @(negedge clk);
    chk("R8 hold", 32'(state), 4);
    drv_req(0);
    wait_state("R8 exit", 0, 10);
    drv_req(1);
    wait_state("R8 restart", 1, 10);
    wait_state("R8 on", 2, 100);

    // R7 during power-up
    drv_req(0);
    wait_state("R7 off", 0, 100);
    drv_req(1);
    repeat (6) @(negedge clk);
    #2 force_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 forced from seq", 32'(state), 4);
    #2 force_n = 1;
    drv_req(0);
    wait_state("R8 exit 2", 0, 10);

    // R10 request back high during power-down
    drv_req(1);
    wait_state("R10 on", 2, 100);
    drv_req(0);
    wait_state("R10 seq off", 3, 10);
    drv_req(1);
    wait_state("R10 finishes off", 0, 100);
    wait_state("R10 restart", 1, 10);
    wait_state("R10 on again", 2, 100);
    drv_req(0);
    wait_state("R10 off", 0, 100);

    // R4 bad slots
    @(negedge clk); #2 slots = pack(0, 0, 1, 2, 3, 4);
    @(negedge clk);
    chk("R4 dup err", 32'(cfg_err), 1);
    drv_req(1);
    repeat (20) @(negedge clk);
    chk("R4 blocked", 32'(state), 0);
    #2 slots = pack(0, 1, 2, 3, 4, 7);
    @(negedge clk);
    chk("R4 range err", 32'(cfg_err), 1);
    chk("R4 still off", 32'(state), 0);
    drv_req(0);

    // R3 zero delay, reversed slots
    @(negedge clk); #2 slots = pack(5, 4, 3, 2, 1, 0); dly = 16'd0;
    drv_req(1);
    wait_state("R3 fast on", 2, 50);
    drv_req(0);
    wait_state("R5 fast off", 0, 50);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule